// File: doc/BRIEF.md
# Hardwired Instruction Sequencer with Interrupt Cycle

This block is the control unit of a 16-bit single-accumulator machine. A step counter, decoded into one-hot step signals, walks through a fixed schedule for every instruction. First comes a three-step fetch. At step 3 an optional pointer dereference is done for indirect memory operands, or a register-class or I/O-class instruction runs and ends. Memory-reference instructions run from step 4 to at most step 6. Every instruction ends by clearing the counter. The block drives load, increment and clear strobes for the address, program-counter, data, instruction and temporary registers. It also drives memory read and write, an operation select for the accumulator unit, and a 3-bit code that picks the source of the shared 16-bit bus.

An interrupt-request flag takes the place of the fetch with a three-step hardware call. It saves the program counter at address 0, continues at address 1, and disarms interrupts. A start input arms the run flag. A halt instruction drops it and freezes the step counter at step 0. The datapath (registers, memory and accumulator unit) lives outside the block. It feeds back the upper instruction nibble, three command bits of the instruction register and a data-register-is-zero flag.

Top module: `accSequencer`

## Requirements
- R1: After reset the run flag is low, the step is 0 and every strobe, the bus code and the accumulator operation are 0. This holds until a one-cycle `start` pulse. The block then runs from the next clock.
- R2: Fetch takes steps 0 to 2. Step 0 puts the program counter on the bus (code 2) and loads the address register. Step 1 reads memory (bus code 7), loads the instruction register and increments the program counter. Step 2 puts the instruction register on the bus (code 5) and loads the address register. It also captures the opcode from `irTop[2:0]` (instruction bits 14..12) and the indirect bit from `irTop[3]` (bit 15).
- R3: At step 3, an opcode other than 7 with the indirect bit set reads memory (bus code 7) into the address register. With the indirect bit clear, step 3 issues no strobe.
- R4: Opcodes 0 (AND), 1 (ADD) and 2 (LOAD) read memory into the data register at step 4. At step 5 they select accumulator operation 1, 2 or 3 respectively and end. Each takes 6 cycles.
- R5: Opcode 3 (STORE) writes the accumulator (bus code 4) to memory at step 4 and ends. Opcode 4 (JUMP) loads the program counter from the address register (bus code 1) at step 4 and ends. Each takes 5 cycles.
- R6: Opcode 5 (CALL) writes the program counter (bus code 2) to memory and increments the address register at step 4. At step 5 it loads the program counter from the address register (bus code 1) and ends. It takes 6 cycles.
- R7: Opcode 6 (increment-and-skip) reads at step 4 and increments the data register at step 5. At step 6 it writes the data register (bus code 3) to memory, increments the program counter only when `drZero` is 1, and ends. It takes 7 cycles, and no step beyond 6 is ever reached.
- R8: Opcode 7 ends at step 3, so it takes 4 cycles. With the indirect bit clear and `irHalt` (instruction bit 0) set, the run flag drops. The step counter then stays at 0 and every strobe stays 0.
- R9: Opcode 7 with the indirect bit set arms interrupts when `irIntOn` (bit 7) is 1 and disarms them when `irIntOff` (bit 6) is 1.
- R10: While running, the interrupt request is set in any step other than 0, 1 or 2 when interrupts are armed and `inFlag` or `outFlag` is 1. The current instruction still finishes.
- R11: With the request set, the fetch strobes are suppressed and a 3-step cycle runs instead. Step 0 clears the address register and loads the temporary register from the bus (code 2). Step 1 writes the temporary register (bus code 6) to memory and clears the program counter. Step 2 increments the program counter, clears the arm flag and the request, and ends.
- R12: At most one bus source is requested per step, and memory read and write are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sets the run flag |
| irTop | input | 4 | Instruction bits 15..12 (indirect bit, opcode) |
| irHalt | input | 1 | Instruction bit 0 |
| irIntOff | input | 1 | Instruction bit 6 |
| irIntOn | input | 1 | Instruction bit 7 |
| drZero | input | 1 | Data register equals zero |
| inFlag | input | 1 | Input device has a character |
| outFlag | input | 1 | Output device is ready |
| arLd | output | 1 | Load address register from bus |
| arInr | output | 1 | Increment address register |
| arClr | output | 1 | Clear address register |
| pcLd | output | 1 | Load program counter from bus |
| pcInr | output | 1 | Increment program counter |
| pcClr | output | 1 | Clear program counter |
| drLd | output | 1 | Load data register from bus |
| drInr | output | 1 | Increment data register |
| irLd | output | 1 | Load instruction register from bus |
| trLd | output | 1 | Load temporary register from bus |
| memRd | output | 1 | Memory read onto bus |
| memWr | output | 1 | Memory write from bus at address register |
| acOp | output | 2 | 0 none, 1 AND, 2 ADD, 3 load from data register |
| busSel | output | 3 | 1 AR, 2 PC, 3 DR, 4 AC, 5 IR, 6 TR, 7 memory |
| isRunning | output | 1 | Run flag |

## Verification
The bench builds the block with its default parameters: a 4-bit step counter and a 3-bit opcode field. That leaves steps 7 to 15 unused, so the bound on the longest instruction can be observed. The bench datapath keeps a 256-word memory because every program stays below that address. The 12-bit address path still carries full bus words, so a wrong bus code corrupts the stored values that the scoreboard compares. Three programs cover direct and indirect operands, the skip taken and not taken, call and return through a pointer, halt, interrupt entry driven by the output flag, and interrupts disarmed before the input flag rises.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int LAST_STEP = 6;

  localparam int OP_AND = 0;
  localparam int OP_ADD = 1;
  localparam int OP_LDA = 2;
  localparam int OP_STA = 3;
  localparam int OP_BUN = 4;
  localparam int OP_BSA = 5;
  localparam int OP_ISZ = 6;
  localparam int OP_SYS = 7;

  localparam int SRC_AR = 1;
  localparam int SRC_PC = 2;
  localparam int SRC_DR = 3;
  localparam int SRC_AC = 4;
  localparam int SRC_IR = 5;
  localparam int SRC_TR = 6;
  localparam int SRC_MEM = 7;
  localparam int NUM_SRC = 8;

  typedef enum logic [1:0] {
    ACOP_NONE = 2'd0,
    ACOP_AND  = 2'd1,
    ACOP_ADD  = 2'd2,
    ACOP_LOAD = 2'd3
  } acOp_e;

  typedef struct packed {
    logic scClr;
    logic latchIr;
    logic runClr;
    logic ienSet;
    logic ienClr;
    logic reqClr;
  } seqCmd_t;

  typedef struct packed {
    logic arLd;
    logic arInr;
    logic arClr;
    logic pcLd;
    logic pcInr;
    logic pcClr;
    logic drLd;
    logic drInr;
    logic irLd;
    logic trLd;
    logic memRd;
    logic memWr;
    acOp_e acOp;
    logic [2:0] busSel;
  } dpStrobes_t;
endpackage

// File: rtl/seqState.sv
module seqState
  import seqPkg::*;
#(
  parameter int STEP_BITS = 4,
  parameter int OPC_BITS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [OPC_BITS:0] irTop,
  input  logic inFlag,
  input  logic outFlag,
  input  seqCmd_t cmd,
  output logic [LAST_STEP:0] tStep,
  output logic [(1<<OPC_BITS)-1:0] opDec,
  output logic indBit,
  output logic running,
  output logic intReq
);
  localparam int NUM_OPS = 1 << OPC_BITS;

  logic [STEP_BITS-1:0] sc;
  logic [NUM_OPS-1:0] nextDec;
  logic ienQ;
  logic fetchStep;
  logic ioPending;

  always_ff @(posedge clk) begin
    if (!rstN) sc <= '0;
    else if (cmd.scClr) sc <= '0;
    else if (running) sc <= sc + 1'b1;
  end

  for (genvar g = 0; g <= LAST_STEP; g++) begin : gStep
    assign tStep[g] = (sc == STEP_BITS'(g));
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : gOp
    assign nextDec[g] = (irTop[OPC_BITS-1:0] == OPC_BITS'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opDec <= '0;
      indBit <= 1'b0;
    end else if (cmd.latchIr) begin
      opDec <= nextDec;
      indBit <= irTop[OPC_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) running <= 1'b0;
    else if (cmd.runClr) running <= 1'b0;
    else if (start) running <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ienQ <= 1'b0;
    else if (cmd.ienClr) ienQ <= 1'b0;
    else if (cmd.ienSet) ienQ <= 1'b1;
  end

  assign fetchStep = |tStep[2:0];
  assign ioPending = inFlag | outFlag;

  always_ff @(posedge clk) begin
    if (!rstN) intReq <= 1'b0;
    else if (cmd.reqClr) intReq <= 1'b0;
    else if (running && !fetchStep && ienQ && ioPending) intReq <= 1'b1;
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    sc <= STEP_BITS'(LAST_STEP)); // R7
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> $stable(sc)); // R8
  AST_REQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReq) |-> $past(ienQ)); // R10
  AST_INT_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    cmd.reqClr |=> (!intReq && !ienQ && sc == '0)); // R11
endmodule

// File: rtl/seqLogic.sv
module seqLogic
  import seqPkg::*;
#(
  parameter int OPC_BITS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic [LAST_STEP:0] tStep,
  input  logic [(1<<OPC_BITS)-1:0] opDec,
  input  logic indBit,
  input  logic running,
  input  logic intReq,
  input  logic drZero,
  input  logic irHalt,
  input  logic irIntOn,
  input  logic irIntOff,
  output seqCmd_t cmd,
  output dpStrobes_t dp
);
  logic fetch0, fetch1, fetch2, int0, int1, int2;
  logic memRef, indirect, regCls, ioCls;
  logic andOp, addOp, ldaOp, staOp, bunOp, bsaOp, iszOp;
  logic [NUM_SRC-1:1] srcReq;

  assign fetch0 = running && !intReq && tStep[0];
  assign fetch1 = running && !intReq && tStep[1];
  assign fetch2 = running && !intReq && tStep[2];
  assign int0 = running && intReq && tStep[0];
  assign int1 = running && intReq && tStep[1];
  assign int2 = running && intReq && tStep[2];

  assign memRef = running && !opDec[OP_SYS];
  assign indirect = memRef && indBit && tStep[3];
  assign regCls = running && opDec[OP_SYS] && !indBit && tStep[3];
  assign ioCls = running && opDec[OP_SYS] && indBit && tStep[3];

  assign andOp = memRef && opDec[OP_AND];
  assign addOp = memRef && opDec[OP_ADD];
  assign ldaOp = memRef && opDec[OP_LDA];
  assign staOp = memRef && opDec[OP_STA];
  assign bunOp = memRef && opDec[OP_BUN];
  assign bsaOp = memRef && opDec[OP_BSA];
  assign iszOp = memRef && opDec[OP_ISZ];

  always_comb begin
    srcReq = '0;
    srcReq[SRC_AR] = (bunOp && tStep[4]) || (bsaOp && tStep[5]);
    srcReq[SRC_PC] = fetch0 || int0 || (bsaOp && tStep[4]);
    srcReq[SRC_DR] = iszOp && tStep[6];
    srcReq[SRC_AC] = staOp && tStep[4];
    srcReq[SRC_IR] = fetch2;
    srcReq[SRC_TR] = int1;
    srcReq[SRC_MEM] = fetch1 || indirect || ((andOp || addOp || ldaOp || iszOp) && tStep[4]);
  end

  always_comb begin
    dp = '0;
    for (int c = 1; c < NUM_SRC; c++) begin
      if (srcReq[c]) dp.busSel = dp.busSel | 3'(c);
    end
    dp.memRd = srcReq[SRC_MEM];
    dp.memWr = (staOp && tStep[4]) || (bsaOp && tStep[4]) || (iszOp && tStep[6]) || int1;
    dp.arLd = fetch0 || fetch2 || indirect;
    dp.arInr = bsaOp && tStep[4];
    dp.arClr = int0;
    dp.pcLd = (bunOp && tStep[4]) || (bsaOp && tStep[5]);
    dp.pcInr = fetch1 || (iszOp && tStep[6] && drZero) || int2;
    dp.pcClr = int1;
    dp.drLd = (andOp || addOp || ldaOp || iszOp) && tStep[4];
    dp.drInr = iszOp && tStep[5];
    dp.irLd = fetch1;
    dp.trLd = int0;
    if (andOp && tStep[5]) dp.acOp = ACOP_AND;
    else if (addOp && tStep[5]) dp.acOp = ACOP_ADD;
    else if (ldaOp && tStep[5]) dp.acOp = ACOP_LOAD;
    else dp.acOp = ACOP_NONE;
  end

  always_comb begin
    cmd.latchIr = fetch2;
    cmd.runClr = regCls && irHalt;
    cmd.ienSet = ioCls && irIntOn;
    cmd.ienClr = (ioCls && irIntOff) || int2;
    cmd.reqClr = int2;
    cmd.scClr = regCls || ioCls || int2
             || ((andOp || addOp || ldaOp) && tStep[5])
             || ((staOp || bunOp) && tStep[4])
             || (bsaOp && tStep[5]) || (iszOp && tStep[6]);
  end

  AST_ONE_BUS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcReq)); // R12
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(dp.memRd && dp.memWr)); // R12
  AST_NO_FETCH_IN_INT: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> !dp.irLd); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (dp == '0)); // R1
endmodule

// File: rtl/accSequencer.sv
module accSequencer
  import seqPkg::*;
#(
  parameter int STEP_BITS = 4,
  parameter int OPC_BITS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [OPC_BITS:0] irTop,
  input  logic irHalt,
  input  logic irIntOff,
  input  logic irIntOn,
  input  logic drZero,
  input  logic inFlag,
  input  logic outFlag,
  output logic arLd,
  output logic arInr,
  output logic arClr,
  output logic pcLd,
  output logic pcInr,
  output logic pcClr,
  output logic drLd,
  output logic drInr,
  output logic irLd,
  output logic trLd,
  output logic memRd,
  output logic memWr,
  output logic [1:0] acOp,
  output logic [2:0] busSel,
  output logic isRunning
);
  localparam int NUM_OPS = 1 << OPC_BITS;

  seqCmd_t cmd;
  dpStrobes_t dp;
  logic [LAST_STEP:0] tStep;
  logic [NUM_OPS-1:0] opDec;
  logic indBit, running, intReq;

  seqState #(.STEP_BITS(STEP_BITS), .OPC_BITS(OPC_BITS)) uState (
    .clk(clk), .rstN(rstN), .start(start), .irTop(irTop),
    .inFlag(inFlag), .outFlag(outFlag), .cmd(cmd),
    .tStep(tStep), .opDec(opDec), .indBit(indBit),
    .running(running), .intReq(intReq)
  );

  seqLogic #(.OPC_BITS(OPC_BITS)) uLogic (
    .clk(clk), .rstN(rstN), .tStep(tStep), .opDec(opDec),
    .indBit(indBit), .running(running), .intReq(intReq),
    .drZero(drZero), .irHalt(irHalt), .irIntOn(irIntOn),
    .irIntOff(irIntOff), .cmd(cmd), .dp(dp)
  );

  assign arLd = dp.arLd;
  assign arInr = dp.arInr;
  assign arClr = dp.arClr;
  assign pcLd = dp.pcLd;
  assign pcInr = dp.pcInr;
  assign pcClr = dp.pcClr;
  assign drLd = dp.drLd;
  assign drInr = dp.drInr;
  assign irLd = dp.irLd;
  assign trLd = dp.trLd;
  assign memRd = dp.memRd;
  assign memWr = dp.memWr;
  assign acOp = dp.acOp;
  assign busSel = dp.busSel;
  assign isRunning = running;
endmodule

// File: tb/tb_accSequencer.sv
module tb_accSequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic inFlag = 1'b0;
  logic outFlag = 1'b0;
  logic arLd, arInr, arClr, pcLd, pcInr, pcClr, drLd, drInr, irLd, trLd;
  logic memRd, memWr, isRunning, drZero;
  logic [1:0] acOp;
  logic [2:0] busSel;

  logic [15:0] mem [0:255];
  logic [11:0] ar, pc, bootPc;
  logic [15:0] dr, ac, ir, tr, busVal;
  logic [27:0] expQ [$];
  int checks = 0;
  int fails = 0;
  int conflicts = 0;

  always #5 clk = ~clk;

  accSequencer dut (
    .clk(clk), .rstN(rstN), .start(start), .irTop(ir[15:12]),
    .irHalt(ir[0]), .irIntOff(ir[6]), .irIntOn(ir[7]), .drZero(drZero),
    .inFlag(inFlag), .outFlag(outFlag), .arLd(arLd), .arInr(arInr),
    .arClr(arClr), .pcLd(pcLd), .pcInr(pcInr), .pcClr(pcClr),
    .drLd(drLd), .drInr(drInr), .irLd(irLd), .trLd(trLd),
    .memRd(memRd), .memWr(memWr), .acOp(acOp), .busSel(busSel),
    .isRunning(isRunning)
  );

  // datapath model driven by the strobes
  assign drZero = (dr == 16'h0000);
  always_comb begin
    case (busSel)
      3'd1: busVal = {4'h0, ar};
      3'd2: busVal = {4'h0, pc};
      3'd3: busVal = dr;
      3'd4: busVal = ac;
      3'd5: busVal = ir;
      3'd6: busVal = tr;
      3'd7: busVal = mem[ar[7:0]];
      default: busVal = 16'h0000;
    endcase
  end

  always @(posedge clk) begin
    if (!rstN) begin
      pc <= bootPc; ar <= '0; dr <= '0; ir <= '0; tr <= '0; ac <= '0;
    end else begin
      if (arClr) ar <= '0; else if (arLd) ar <= busVal[11:0]; else if (arInr) ar <= ar + 1'b1;
      if (pcClr) pc <= '0; else if (pcLd) pc <= busVal[11:0]; else if (pcInr) pc <= pc + 1'b1;
      if (drLd) dr <= busVal; else if (drInr) dr <= dr + 1'b1;
      if (irLd) ir <= busVal;
      if (trLd) tr <= busVal;
      case (acOp)
        2'd1: ac <= ac & dr;
        2'd2: ac <= ac + dr;
        2'd3: ac <= dr;
        default: ;
      endcase
      if (memWr) mem[ar[7:0]] <= busVal;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every memory write is compared with the next expected item
  always @(negedge clk) begin
    if (rstN && memRd && memWr) conflicts++;
    if (rstN && memWr) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: unexpected write actual %0h:%0h expected none", ar, busVal);
      end else begin
        logic [27:0] e;
        e = expQ.pop_front();
        check("R5", "write address", int'(ar), int'(e[27:16]));
        check("R7", "write data", int'(busVal), int'(e[15:0]));
      end
    end
  end

  task automatic expectWrite(input logic [11:0] a, input logic [15:0] d);
    expQ.push_back({a, d});
  endtask

  task automatic doReset(input logic [11:0] p);
    bootPc = p;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runProg(output int cyc);
    cyc = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (isRunning) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic quietCheck(input string req);
    int bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if ({arLd, arInr, arClr, pcLd, pcInr, pcClr, drLd, drInr, irLd, trLd,
           memRd, memWr, acOp, busSel, isRunning} != '0) bad++;
    end
    check(req, "idle cycles with activity", bad, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: cycles actual 20000 expected fewer");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
    // program one at 0x10
    mem[8'h10] = 16'h2040; mem[8'h11] = 16'h9041; mem[8'h12] = 16'h0043;
    mem[8'h13] = 16'h3044; mem[8'h14] = 16'h6045; mem[8'h15] = 16'h7001;
    mem[8'h16] = 16'h6046; mem[8'h17] = 16'h5050; mem[8'h18] = 16'h4020;
    mem[8'h20] = 16'h7001; mem[8'h51] = 16'hC050;
    mem[8'h40] = 16'h1234; mem[8'h41] = 16'h0042; mem[8'h42] = 16'h0F0F;
    mem[8'h43] = 16'hFF00; mem[8'h45] = 16'hFFFF; mem[8'h46] = 16'h0005;
    // program two at 0x30, handler at 1
    mem[8'h30] = 16'hF080; mem[8'h31] = 16'h2040; mem[8'h01] = 16'h7001;
    // program three at 0x60
    mem[8'h60] = 16'hF080; mem[8'h61] = 16'hF040; mem[8'h62] = 16'h2040;
    mem[8'h63] = 16'h7001;

    doReset(12'h010);
    quietCheck("R1"); // idle after reset, no start

    expectWrite(12'h044, 16'h2100);
    expectWrite(12'h045, 16'h0000);
    expectWrite(12'h046, 16'h0006);
    expectWrite(12'h050, 16'h0018);
    runProg(cyc);
    check("R4", "accumulator after LOAD/ADD indirect/AND", int'(ac), 16'h2100);
    check("R3", "indirect sum path via mem 0x42", int'(mem[8'h42]), 16'h0F0F);
    check("R6", "pc after call, pointer return and jump to halt", int'(pc), 12'h021);
    check("R2", "run cycles of program one", cyc, 57);
    check("R7", "pending scoreboard items", expQ.size(), 0);
    quietCheck("R8"); // halted stays quiet

    outFlag = 1'b1;
    doReset(12'h030);
    expectWrite(12'h000, 16'h0032);
    runProg(cyc);
    check("R11", "pc after interrupt entry and halt at 1", int'(pc), 12'h002);
    check("R10", "load finished before interrupt", int'(ac), 16'h1234);
    check("R11", "run cycles with interrupt", cyc, 17);
    check("R11", "pending scoreboard items", expQ.size(), 0);
    outFlag = 1'b0;

    doReset(12'h060);
    fork
      runProg(cyc);
      begin
        wait (ir == 16'h2040);
        inFlag = 1'b1;
      end
    join
    check("R9", "pc after disarm, no interrupt taken", int'(pc), 12'h064);
    check("R9", "run cycles with interrupts disarmed", cyc, 18);
    check("R9", "unexpected writes", expQ.size(), 0);
    check("R12", "read and write together", conflicts, 0);
    inFlag = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule